// File: doc/BRIEF.md
# Answer Countdown Timer with Alarm

This block times the answer period of a quiz round. A host start pulse loads a count of thirty seconds. The count then drops by one each second and is shown as two decimal digits, each with its own seven-segment code. When the count reaches zero, a buzzer sounds a 1 kHz tone for one second. At the same time a round-ready flag is raised, so the next buzz-in round may begin.

The one-second step and the tone are both derived from the system clock by counters. The default period assumes a 50 MHz clock. Both periods are parameters, so a small setting can be used for simulation. A start pulse that arrives during a count or during the alarm begins a fresh thirty-second count at once.

Top module: `answer_countdown`

## Requirements
- R1: While synchronous reset is high, and on the cycle after it, both digits read 0. The running flag and the buzzer are low, and round-ready is high.
- R2: Counting is in BCD: 30, 29, 28, …, 01, 00. When the units digit is 0, it wraps to 9 and the tens digit drops by one.
- R3: The one-second prescaler restarts on every start pulse. The first step therefore lands exactly TICK_CYCLES cycles after the start edge, and the count stays fixed between steps.
- R4: A start pulse loads tens=3 and units=0 on the next edge, even while a count is already running.
- R5: Round-ready goes low on start. It stays low until the edge on which the count becomes 00, and it is high from that edge onward.
- R6: The alarm window opens on the edge on which the count becomes 00 and lasts exactly TICK_CYCLES cycles. Outside this window the buzzer is low.
- R7: Inside the alarm window the buzzer is a square tone. It is high for the first TONE_HALF cycles, then alternates every TONE_HALF cycles.
- R8: Each segment output is active high, with bit 0 = segment a through bit 6 = segment g. The codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R9: The running flag is high from the edge after start until the edge on which the count becomes 00.
- R10: A start pulse during the alarm window silences the buzzer on the next edge and begins a new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Host start pulse, one cycle |
| tens_bcd | output | 4 | Tens digit of the remaining seconds |
| units_bcd | output | 4 | Units digit of the remaining seconds |
| tens_seg | output | 7 | Segment code of the tens digit (bit 0 = a) |
| units_seg | output | 7 | Segment code of the units digit (bit 0 = a) |
| buzzer | output | 1 | Tone drive during the alarm |
| round_ready | output | 1 | A new buzz-in round may begin |
| running | output | 1 | A countdown is in progress |

## Verification
Every output is registered, or decoded straight from a register, so each result appears one edge after the stimulus that causes it. Counting the start edge as cycle zero:
- The load appears at cycle 0.
- Step n appears at cycle n·TICK_CYCLES.
- Expiry and the opening of the alarm window appear at cycle 30·TICK_CYCLES.
- The window closes TICK_CYCLES cycles after it opens.

The bench drives inputs and samples outputs on falling edges. After each start it walks every cycle and compares each output against values it works out from the cycle index alone. It does this on a fresh count, on a restart in mid-phase and on a restart during the alarm.

// File: rtl/answer_countdown.sv
module answer_countdown #(
  parameter int unsigned TICK_CYCLES = 50_000_000,
  parameter int unsigned TONE_HALF   = 25_000,
  parameter int unsigned START_TENS  = 3,
  parameter int unsigned START_UNITS = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic [3:0] tens_bcd,
  output logic [3:0] units_bcd,
  output logic [6:0] tens_seg,
  output logic [6:0] units_seg,
  output logic       buzzer,
  output logic       round_ready,
  output logic       running
);
  localparam int TW = $clog2(TICK_CYCLES) + 1;
  localparam int HW = $clog2(TONE_HALF) + 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(TONE_HALF - 1);

  logic [TW-1:0] pre_cnt, alarm_cnt;
  logic [HW-1:0] tone_cnt;
  logic [3:0]    tens_q, units_q;
  logic          alarm, tone, run_q, ready_q;

  wire tick   = run_q && (pre_cnt == TICK_LAST);
  wire at_one = (tens_q == 4'd0) && (units_q == 4'd1);

  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0: seg7 = 7'h3F;
      4'd1: seg7 = 7'h06;
      4'd2: seg7 = 7'h5B;
      4'd3: seg7 = 7'h4F;
      4'd4: seg7 = 7'h66;
      4'd5: seg7 = 7'h6D;
      4'd6: seg7 = 7'h7D;
      4'd7: seg7 = 7'h07;
      4'd8: seg7 = 7'h7F;
      4'd9: seg7 = 7'h6F;
      default: seg7 = 7'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tens_q    <= '0;
      units_q   <= '0;
      run_q     <= 1'b0;
      ready_q   <= 1'b1;
      alarm     <= 1'b0;
      tone      <= 1'b0;
      pre_cnt   <= '0;
      alarm_cnt <= '0;
      tone_cnt  <= '0;
    end else if (start) begin
      tens_q  <= 4'(START_TENS);
      units_q <= 4'(START_UNITS);
      run_q   <= 1'b1;
      ready_q <= 1'b0;
      alarm   <= 1'b0;
      pre_cnt <= '0;
    end else begin
      if (run_q) begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) begin
          if (units_q == 4'd0) begin
            units_q <= 4'd9;
            tens_q  <= tens_q - 4'd1;
          end else begin
            units_q <= units_q - 4'd1;
          end
          if (at_one) begin
            run_q     <= 1'b0;
            ready_q   <= 1'b1;
            alarm     <= 1'b1;
            alarm_cnt <= TICK_LAST;
            tone      <= 1'b1;
            tone_cnt  <= '0;
          end
        end
      end
      if (alarm) begin
        if (alarm_cnt == '0) alarm <= 1'b0;
        else alarm_cnt <= alarm_cnt - 1'b1;
        if (tone_cnt == HALF_LAST) begin
          tone     <= ~tone;
          tone_cnt <= '0;
        end else begin
          tone_cnt <= tone_cnt + 1'b1;
        end
      end
    end
  end

  assign tens_bcd    = tens_q;
  assign units_bcd   = units_q;
  assign tens_seg    = seg7(tens_q);
  assign units_seg   = seg7(units_q);
  assign buzzer      = alarm & tone;
  assign round_ready = ready_q;
  assign running     = run_q;

  assert_digits_bcd_R2: assert property (@(posedge clk) disable iff (rst)
    units_q <= 4'd9 && tens_q <= 4'(START_TENS));
  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> run_q && tens_q == 4'(START_TENS) && units_q == 4'(START_UNITS) && !ready_q);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    run_q && !tick && !start |=> $stable(tens_q) && $stable(units_q));
  assert_expire_R5: assert property (@(posedge clk) disable iff (rst)
    run_q && tick && at_one && !start |=> !run_q && ready_q && alarm && tens_q == 4'd0 && units_q == 4'd0);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(run_q && ready_q));
  assert_buzz_idle_R6: assert property (@(posedge clk) disable iff (rst)
    buzzer |-> !run_q && ready_q);
  assert_start_mutes_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> !buzzer);
endmodule

// File: tb/test_answer_countdown.sv
module test_answer_countdown;
  localparam int CLK_PERIOD = 20;
  localparam int TICK = 8;
  localparam int HALF = 2;
  localparam int EXPIRE = 30 * TICK;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [3:0] tens_bcd, units_bcd;
  logic [6:0] tens_seg, units_seg;
  logic buzzer, round_ready, running;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [6:0] segtab [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  always #(CLK_PERIOD/2) clk = ~clk;

  answer_countdown #(.TICK_CYCLES(TICK), .TONE_HALF(HALF)) i_answer_countdown (
    .clk(clk), .rst(rst), .start(start), .tens_bcd(tens_bcd), .units_bcd(units_bcd),
    .tens_seg(tens_seg), .units_seg(units_seg), .buzzer(buzzer),
    .round_ready(round_ready), .running(running));

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check_idle(input string tag);
    check({tag, " tens"}, tens_bcd, 0);
    check({tag, " units"}, units_bcd, 0);
    check({tag, " running"}, running, 0);
    check({tag, " ready"}, round_ready, 1);
    check({tag, " buzzer"}, buzzer, 0);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // k = cycles since the start edge, sampled on the falling edge
  task automatic sweep(input int last);
    for (int k = 0; k <= last; k++) begin
      int rem = (k < EXPIRE) ? 30 - k / TICK : 0;
      int j = k - EXPIRE;
      int exp_buz = (j >= 0 && j < TICK) ? (((j / HALF) % 2) == 0) : 0;
      check((k == TICK - 1 || k == TICK) ? "R3 first step" : "R2 count", tens_bcd, rem / 10);
      check("R2 units", units_bcd, rem % 10);
      check("R8 tens seg", tens_seg, segtab[rem / 10]);
      check("R8 units seg", units_seg, segtab[rem % 10]);
      check("R9 running", running, k < EXPIRE);
      check("R5 round_ready", round_ready, k >= EXPIRE);
      check((j >= 0 && j < TICK) ? "R7 tone" : "R6 alarm window", buzzer, exp_buz);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    pulse_start();
    sweep(EXPIRE + TICK + 4);
    check_idle("R6 after alarm");
    // restart mid-phase of the prescaler
    pulse_start();
    sweep(100);
    pulse_start();
    check("R4 restart tens", tens_bcd, 3);
    check("R4 restart units", units_bcd, 0);
    sweep(EXPIRE + 3);
    // start during the alarm window
    pulse_start();
    check("R10 buzzer muted", buzzer, 0);
    check("R10 running", running, 1);
    sweep(EXPIRE + TICK + 2);
    // reset during a count
    pulse_start();
    sweep(50);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1 mid-count reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 released");
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end
endmodule